// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block multiplies two 16-bit signed fractional operands (Q15) and folds the result into a 24-bit accumulator in one ALU cycle. Each operand is captured into its own register from a shared data input. The multiplier registers the full 32-bit signed product on every clock. An alignment stage then converts that product to the accumulator's 24-bit width, with or without the one-bit shift that removes the redundant sign bit of a fractional product.

The ALU either loads, adds, subtracts or clears the accumulator. Sums and differences that leave the signed 24-bit range are clamped to the nearest extreme, and this sets a sticky overflow flag. Zero and negative flags follow the accumulator after each operation. The surrounding sequencer owns instruction decode, memory and the ordering of loads and operations. The block itself holds only the operand, product, accumulator and flag state.

Top module: `frac_mac`

## Requirements
- R1: After reset the accumulator reads 0, the zero flag is 1, and the negative and overflow flags are 0.
- R2: `data_in` is captured into operand X on a clock edge with `ld_x` high and into operand Y on an edge with `ld_y` high. The product of X and Y is registered on the next edge. An operation issued on the edge after that uses this product. With `frac_mode`=1 the value presented to the ALU is bits 30..7 of the 32-bit signed product.
- R3: With `frac_mode`=0 the value presented to the ALU is bits 31..8 of the product, with no shift.
- R4: With `frac_mode`=1, the product of 0x8000 by 0x8000 (-1.0 times -1.0) is presented as 0x7FFFFF.
- R5: `op_sel`=01 with `op_en` high adds the aligned product to the accumulator. `op_sel`=00 loads the aligned product into the accumulator.
- R6: `op_sel`=10 with `op_en` high subtracts the aligned product from the accumulator.
- R7: An add or subtract whose true result exceeds 0x7FFFFF leaves 0x7FFFFF in the accumulator and sets the overflow flag.
- R8: An add or subtract whose true result is below -0x800000 leaves 0x800000 in the accumulator and sets the overflow flag.
- R9: Once set, the overflow flag stays at 1 through later operations until a clear operation or reset.
- R10: `op_sel`=11 with `op_en` high sets the accumulator to 0 and the overflow flag to 0.
- R11: On an edge with `op_en` low, the accumulator and all three flags keep their values, even when operands are loaded.
- R12: After each operation, the zero flag is 1 exactly when the accumulator is 0, and the negative flag equals accumulator bit 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 16 | Operand data from memory |
| ld_x | input | 1 | Capture `data_in` into operand X |
| ld_y | input | 1 | Capture `data_in` into operand Y |
| frac_mode | input | 1 | 1: fractional alignment (shift left by one), 0: plain truncation |
| op_en | input | 1 | Perform the operation chosen by `op_sel` this edge |
| op_sel | input | 2 | 00 load, 01 add, 10 subtract, 11 clear |
| acc_out | output | 24 | Accumulator value |
| flag_zero | output | 1 | Accumulator is zero |
| flag_neg | output | 1 | Accumulator is negative |
| flag_ovf | output | 1 | Sticky saturation flag |

## Verification
The checker watches every cycle for the following properties. The accumulator and flags hold while `op_en` is low. A clear always yields zero with the overflow flag low. The overflow flag never drops without a clear. A fresh overflow always leaves one of the two saturation values in the accumulator. The zero and negative flags always agree with the accumulator. Only the bench scenarios show the values themselves: correct product alignment in both modes, the -1.0 times -1.0 clamp, and arithmetic results of load, add and subtract chains that cross both range limits.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_SUB   = 2'b10,
        OP_CLEAR = 2'b11
    } mac_op_e;

endpackage

// File: rtl/frac_mac_mul.sv
module frac_mac_mul #(
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         data_in,
    input  logic                  ld_x,
    input  logic                  ld_y,
    output logic signed [2*DW-1:0] prod_q
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [PW-1:0] p;
    } mul_state_t;

    mul_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_x) st_d.x = data_in;
        if (ld_y) st_d.y = data_in;
        st_d.p = PW'($signed(st_q.x) * $signed(st_q.y));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_q = $signed(st_q.p);
endmodule

// File: rtl/frac_mac_align.sv
module frac_mac_align #(
    parameter int DW = 16,
    parameter int AW = 24
) (
    input  logic signed [2*DW-1:0] prod,
    input  logic                   frac_mode,
    output logic signed [AW-1:0]   aligned
);
    localparam int PW = 2 * DW;
    localparam logic [AW-1:0] MAX_POS = {1'b0, {(AW-1){1'b1}}};

    logic [PW-1:0] shifted;

    always_comb begin
        shifted = {prod[PW-2:0], 1'b0};
        if (!frac_mode) begin
            aligned = prod[PW-1:PW-AW];
        end else if (prod[PW-1] != prod[PW-2]) begin
            // only the most negative squared reaches here
            aligned = MAX_POS;
        end else begin
            aligned = shifted[PW-1:PW-AW];
        end
    end
endmodule

// File: rtl/frac_mac_alu.sv
module frac_mac_alu
    import frac_mac_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic signed [AW-1:0] acc,
    input  logic signed [AW-1:0] operand,
    input  mac_op_e              op,
    output logic signed [AW-1:0] result,
    output logic                 sat
);
    localparam logic [AW-1:0] MAX_POS = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] MAX_NEG = {1'b1, {(AW-1){1'b0}}};

    logic signed [AW:0] wide;

    always_comb begin
        wide   = '0;
        result = '0;
        sat    = 1'b0;
        unique case (op)
            OP_LOAD:  result = operand;
            OP_CLEAR: result = '0;
            OP_ADD, OP_SUB: begin
                if (op == OP_ADD) wide = {acc[AW-1], acc} + {operand[AW-1], operand};
                else              wide = {acc[AW-1], acc} - {operand[AW-1], operand};
                if (wide[AW] != wide[AW-1]) begin
                    sat    = 1'b1;
                    result = wide[AW] ? MAX_NEG : MAX_POS;
                end else begin
                    result = wide[AW-1:0];
                end
            end
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
    import frac_mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data_in,
    input  logic          ld_x,
    input  logic          ld_y,
    input  logic          frac_mode,
    input  logic          op_en,
    input  logic [1:0]    op_sel,
    output logic [AW-1:0] acc_out,
    output logic          flag_zero,
    output logic          flag_neg,
    output logic          flag_ovf
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          zero;
        logic          neg;
        logic          ovf;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] aligned;
    logic signed [AW-1:0] alu_res;
    logic                 alu_sat;
    mac_op_e              op;

    assign op = mac_op_e'(op_sel);

    frac_mac_mul #(.DW(DW)) u_mul (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .ld_x(ld_x), .ld_y(ld_y), .prod_q(prod)
    );

    frac_mac_align #(.DW(DW), .AW(AW)) u_align (
        .prod(prod), .frac_mode(frac_mode), .aligned(aligned)
    );

    frac_mac_alu #(.AW(AW)) u_alu (
        .acc($signed(st_q.acc)), .operand(aligned), .op(op),
        .result(alu_res), .sat(alu_sat)
    );

    always_comb begin
        st_d = st_q;
        if (op_en) begin
            st_d.acc  = alu_res;
            st_d.zero = (alu_res == '0);
            st_d.neg  = alu_res[AW-1];
            if (op == OP_CLEAR) st_d.ovf = 1'b0;
            else if (alu_sat)   st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{acc: '0, zero: 1'b1, neg: 1'b0, ovf: 1'b0};
        else        st_q <= st_d;
    end

    assign acc_out   = st_q.acc;
    assign flag_zero = st_q.zero;
    assign flag_neg  = st_q.neg;
    assign flag_ovf  = st_q.ovf;
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_en,
    input logic [1:0]    op_sel,
    input logic [AW-1:0] acc_out,
    input logic          flag_zero,
    input logic          flag_neg,
    input logic          flag_ovf
);
    localparam logic [AW-1:0] MAX_POS = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] MAX_NEG = {1'b1, {(AW-1){1'b0}}};

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(acc_out) && $stable(flag_zero) && $stable(flag_neg) && $stable(flag_ovf));

    assert_clear_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op_sel == 2'b11 |=> acc_out == '0 && !flag_ovf);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf && !(op_en && op_sel == 2'b11) |=> flag_ovf);

    assert_sat_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> acc_out == MAX_POS || acc_out == MAX_NEG);

    assert_flags_track_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero == (acc_out == '0) && flag_neg == acc_out[AW-1]);
endmodule

bind frac_mac frac_mac_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
    .acc_out(acc_out), .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf)
);

// File: tb/frac_mac_bench.sv
module frac_mac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic        ld_x = 1'b0, ld_y = 1'b0, frac_mode = 1'b1, op_en = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [23:0] acc_out;
    logic        flag_zero, flag_neg, flag_ovf;

    frac_mac u_frac_mac (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .ld_x(ld_x), .ld_y(ld_y),
        .frac_mode(frac_mode), .op_en(op_en), .op_sel(op_sel),
        .acc_out(acc_out), .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [23:0] acc;
        logic        zero, neg, ovf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, fails = 0;
    bit   pend = 0;
    bit   done = 0;

    logic [23:0] m_acc = '0;
    logic        m_ovf = 1'b0;

    function automatic logic [23:0] align_m(logic [15:0] x, logic [15:0] y, bit fr);
        logic [31:0] p;
        p = 32'($signed(x) * $signed(y));
        if (!fr) return p[31:8];
        if (p == 32'h4000_0000) return 24'h7FFFFF;
        return p[30:7];
    endfunction

    task automatic run(logic [15:0] x, logic [15:0] y, bit fr, bit en, logic [1:0] op, string tag);
        logic [23:0] a;
        longint s;
        a = align_m(x, y, fr);
        if (en) begin
            case (op)
                2'b00: m_acc = a;
                2'b11: begin m_acc = '0; m_ovf = 1'b0; end
                default: begin
                    if (op == 2'b01) s = longint'($signed(m_acc)) + longint'($signed(a));
                    else             s = longint'($signed(m_acc)) - longint'($signed(a));
                    if (s > 64'sd8388607)       begin m_acc = 24'h7FFFFF; m_ovf = 1'b1; end
                    else if (s < -64'sd8388608) begin m_acc = 24'h800000; m_ovf = 1'b1; end
                    else m_acc = s[23:0];
                end
            endcase
        end
        exp_q.push_back('{m_acc, m_acc == '0, m_acc[23], m_ovf, tag});
        @(negedge clk); data_in = x; ld_x = 1;
        @(negedge clk); ld_x = 0; data_in = y; ld_y = 1;
        @(negedge clk); ld_y = 0;
        @(negedge clk); frac_mode = fr; op_sel = op; op_en = en;
        @(posedge clk); #1 pend = 1;
        @(negedge clk); op_en = 0;
    endtask

    always @(negedge clk) begin
        if (pend) begin
            exp_t e;
            pend = 0;
            e = exp_q.pop_front();
            checks++;
            if (acc_out !== e.acc || flag_zero !== e.zero || flag_neg !== e.neg || flag_ovf !== e.ovf) begin
                fails++;
                $display("FAIL %s: acc=%h z=%b n=%b v=%b expected acc=%h z=%b n=%b v=%b",
                         e.tag, acc_out, flag_zero, flag_neg, flag_ovf, e.acc, e.zero, e.neg, e.ovf);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (acc_out !== 24'h0 || flag_zero !== 1'b1 || flag_neg !== 1'b0 || flag_ovf !== 1'b0) begin
            fails++;
            $display("FAIL R1: acc=%h z=%b n=%b v=%b expected acc=000000 z=1 n=0 v=0",
                     acc_out, flag_zero, flag_neg, flag_ovf);
        end
        rst_n = 1;
        @(negedge clk);
        run(16'h4000, 16'h4000, 1, 1, 2'b00, "R2 frac load 0.5*0.5");
        run(16'h4000, 16'h4000, 1, 1, 2'b01, "R5 add");
        run(16'h2000, 16'hE000, 1, 1, 2'b01, "R5 add negative product");
        run(16'h1234, 16'h5678, 1, 1, 2'b10, "R6 subtract");
        run(16'h7FFF, 16'h7FFF, 1, 1, 2'b01, "R7 add to positive saturation");
        run(16'h4000, 16'h4000, 1, 1, 2'b01, "R9 ovf stays while saturated");
        run(16'h4000, 16'h4000, 1, 1, 2'b10, "R9 ovf sticky after subtract");
        run(16'h7FFF, 16'h7FFF, 1, 0, 2'b11, "R11 idle clear request ignored");
        run(16'h1111, 16'h2222, 1, 1, 2'b11, "R10 clear");
        run(16'h8000, 16'h8000, 1, 1, 2'b00, "R4 minus one squared");
        run(16'h7FFF, 16'h7FFF, 0, 1, 2'b00, "R3 integer alignment");
        run(16'h8000, 16'h7FFF, 1, 1, 2'b00, "R12 negative load");
        run(16'h8000, 16'h7FFF, 1, 1, 2'b01, "R8 negative saturation");
        run(16'h0001, 16'h0001, 1, 0, 2'b00, "R11 idle keeps saturated value");
        run(16'h4000, 16'h4000, 1, 1, 2'b11, "R10 clear after negative overflow");
        run(16'h4000, 16'h4000, 1, 1, 2'b00, "R12 load for zero test");
        run(16'h4000, 16'h4000, 1, 1, 2'b10, "R12 subtract to zero");
        run(16'h8000, 16'h4000, 0, 1, 2'b10, "R6 integer subtract of negative");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule